// File: doc/BRIEF.md
# Configuration Register Auto-Reset Controller

This block is a slice of the configuration space of a bus-master peripheral. It holds three 32-bit registers: a command register with the bus-master enable, an interface control register with an auto-reset disable bit, and a miscellaneous control register with a software-reset bit. The host writes and reads these registers through a simple port with a byte address, 32-bit data and four byte enables. Reads return data combinationally for the address on the port.

The block turns certain host writes into a device-wide software reset. A write that clears the bus-master enable from one to zero starts this reset, unless auto-reset has been disabled. A write of one to the software-reset bit starts the same reset. The reset leaves the block as a registered pulse of fixed length. The DMA engine uses that pulse to drop pending transfers. The bus-master enable also leaves the block as a level output, so the engine can stop further memory accesses.

Top module: `cfg_autoreset_ctrl`

## Requirements
- R1: After a synchronous hardware reset (rst_n low at a clock edge), all three registers read 0, `sw_rst` is low and `bus_master_en` is low.
- R2: The registers decode at byte addresses 0x04 (command), 0x54 (interface control) and 0x40 (miscellaneous control). Address bits [1:0] are ignored, and other addresses read 0. Byte enable k controls bits [8k+7:8k]. Reads return the addressed register in the same cycle.
- R3: Take a write to 0x04 with byte enable 0 set and data bit 2 at 0. If the stored bit 2 is 1, interface-control bit 16 is 0 and no reset pulse is active, then `sw_rst` goes high in the cycle after the write edge. It stays high for exactly RST_CYCLES cycles.
- R4: While interface-control bit 16 is 1, a write that clears command bit 2 clears the bit and produces no `sw_rst`.
- R5: A write to 0x04 that leaves bit 2 at 0 when it was already 0, or that writes bit 2 as 1, produces no `sw_rst`.
- R6: A write whose byte enable for the lane holding a control bit is 0 leaves that bit unchanged. For command bit 2 it also produces no `sw_rst`.
- R7: When no pulse is active, a write of 1 to bit 31 of 0x40 with byte enable 3 set starts the same RST_CYCLES-cycle pulse. Bit 31 reads 1 exactly while `sw_rst` is high and reads 0 once the pulse ends.
- R8: A software reset clears command bit 2 at its starting edge and holds it at 0 while the pulse lasts. Host writes of 1 to it during the pulse have no effect. No write lengthens a running pulse.
- R9: A software reset leaves the interface control register, command bits other than bit 2 and miscellaneous bits 30:0 unchanged.
- R10: Reserved bits of the interface control register keep whatever value was last written to them.
- R11: `bus_master_en` equals command bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset; restores all defaults |
| cfg_wr | input | 1 | Write strobe, one write per cycle it is high |
| cfg_addr | input | 8 | Byte address for both writes and reads |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| bus_master_en | output | 1 | Current bus-master enable |
| sw_rst | output | 1 | Software reset pulse, RST_CYCLES cycles long |

## Verification
The trigger is driven with five write patterns on the command register. They are: a one-to-zero clear with auto-reset enabled, a repeated clear of an already-zero bit, a rewrite of a set bit, a clear with auto-reset disabled, and a clear with byte enable 0 off. Only the first of these may raise `sw_rst`. The same clear is also made through byte enable 0 alone, which shows that the trigger follows lane qualification and not full-word writes. The software-reset bit is written and then read back during and after its pulse. During that pulse a write of 1 to bus-master tells apart a held bit from a freshly writable one. Reads of the interface control register with odd reserved-bit values show that a reset spares the other registers.

// File: rtl/cfgar_pkg.sv
// Package: shared constants for the configuration auto-reset controller.
// Assumes a 32-bit data path with 8-bit byte addresses, word-aligned registers.
package cfgar_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int LANES    = DATA_W / 8;
    localparam int NUM_REGS = 3;

    // Register indices inside the slice
    localparam int IDX_CMD  = 0;
    localparam int IDX_ICTL = 1;
    localparam int IDX_MISC = 2;

    // Byte addresses, in index order
    localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] = '{8'h04, 8'h54, 8'h40};

    // Control bit positions
    localparam int BM_BIT       = 2;
    localparam int AUTO_OFF_BIT = 16;
    localparam int SWRST_BIT    = 31;

    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cfgar_decode.sv
// Module: address decoder producing one select line per register.
// Assumes the low two address bits are don't-care; enable gates every select.
module cfgar_decode
    import cfgar_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_REGS-1:0] sel
);
    // Compare the word address with each register's address.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = en && ((addr & WORD_MASK) == REG_ADDR[i]);
    end
endmodule

// File: rtl/cfgar_reg.sv
// Module: one 32-bit configuration register with byte-lane write merge.
// Assumes set and clear masks come from control logic; clear wins over set,
// and both win over the host write.
module cfgar_reg
    import cfgar_pkg::*;
#(
    parameter word_t RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  word_t            wdata,
    input  logic [LANES-1:0] be,
    input  word_t            set_mask,
    input  word_t            clr_mask,
    output word_t            q
);
    word_t merged;
    word_t nxt;

    // Per-lane merge of host data with the stored value.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = (wr_en && be[b]) ? wdata[8*b +: 8] : q[8*b +: 8];
    end

    // Apply hardware side effects on top of the host write.
    always_comb begin
        nxt = (merged | set_mask) & ~clr_mask;
    end

    // Register storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= nxt;
    end

    // R8: a cleared bit reads zero after the edge, whatever the host wrote.
    assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((q & $past(clr_mask)) == '0));
endmodule

// File: rtl/cfgar_trigger.sv
// Module: decides when a host write starts a software reset.
// Assumes write selects are already address-decoded and only one write per cycle.
module cfgar_trigger
    import cfgar_pkg::*;
(
    input  logic cmd_wr,
    input  logic cmd_lane0,
    input  logic wdata_bm,
    input  logic bm_q,
    input  logic auto_off_q,
    input  logic misc_wr,
    input  logic misc_lane3,
    input  logic wdata_swrst,
    input  logic pulse_active,
    output logic start
);
    logic bm_clear_hit;
    logic swrst_hit;

    // A qualified one-to-zero write of the bus-master bit with auto-reset allowed.
    always_comb begin
        bm_clear_hit = cmd_wr && cmd_lane0 && bm_q && !wdata_bm && !auto_off_q;
    end

    // An explicit write of one to the software-reset bit.
    always_comb begin
        swrst_hit = misc_wr && misc_lane3 && wdata_swrst;
    end

    // Either source starts a pulse unless one is already running.
    always_comb begin
        start = !pulse_active && (bm_clear_hit || swrst_hit);
    end
endmodule

// File: rtl/cfgar_pulse.sv
// Module: fixed-length reset pulse generator.
// Assumes CYCLES >= 1; start is ignored by the caller while the pulse is active.
module cfgar_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Pulse is high while the counter is non-zero.
    always_comb begin
        active = (cnt != '0);
        last   = (cnt == CW'(1));
    end

    // R3: a start is followed by an active pulse.
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
    // R8: no start arrives while a pulse runs, so a pulse is never lengthened.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !start);
    // R3: the counter never exceeds the configured length.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
endmodule

// File: rtl/cfg_autoreset_ctrl.sv
// Module: configuration register slice that turns a bus-master clear, or an
// explicit software-reset write, into a fixed-length device reset pulse.
// Assumes one host access per cycle; reads are combinational on cfg_addr.
module cfg_autoreset_ctrl
    import cfgar_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [LANES-1:0]  cfg_be,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_master_en,
    output logic              sw_rst
);
    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] rd_sel;
    word_t               reg_q   [NUM_REGS];
    word_t               set_m   [NUM_REGS];
    word_t               clr_m   [NUM_REGS];
    logic                start;
    logic                active;
    logic                last;

    cfgar_decode u_wdec (.en(cfg_wr), .addr(cfg_addr), .sel(wr_sel));
    cfgar_decode u_rdec (.en(1'b1),   .addr(cfg_addr), .sel(rd_sel));

    cfgar_trigger u_trig (
        .cmd_wr      (wr_sel[IDX_CMD]),
        .cmd_lane0   (cfg_be[BM_BIT/8]),
        .wdata_bm    (cfg_wdata[BM_BIT]),
        .bm_q        (reg_q[IDX_CMD][BM_BIT]),
        .auto_off_q  (reg_q[IDX_ICTL][AUTO_OFF_BIT]),
        .misc_wr     (wr_sel[IDX_MISC]),
        .misc_lane3  (cfg_be[SWRST_BIT/8]),
        .wdata_swrst (cfg_wdata[SWRST_BIT]),
        .pulse_active(active),
        .start       (start)
    );

    cfgar_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .active(active),
        .last  (last)
    );

    // Side-effect masks: the reset clears bus-master and owns the reset bit.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            set_m[i] = '0;
            clr_m[i] = '0;
        end
        clr_m[IDX_CMD][BM_BIT]     = start || active;
        set_m[IDX_MISC][SWRST_BIT] = start || (active && !last);
        clr_m[IDX_MISC][SWRST_BIT] = last;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        cfgar_reg #(.RESET_VAL('0)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[i]),
            .wdata   (cfg_wdata),
            .be      (cfg_be),
            .set_mask(set_m[i]),
            .clr_mask(clr_m[i]),
            .q       (reg_q[i])
        );
    end

    // Read mux: OR of the selected register values.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel[i]) cfg_rdata = cfg_rdata | reg_q[i];
        end
    end

    // Outputs toward the bus and DMA logic.
    always_comb begin
        bus_master_en = reg_q[IDX_CMD][BM_BIT];
        sw_rst        = active;
    end

    // R2: at most one register answers a given address.
    assert_onehot_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    // R3: a qualified bus-master clear with auto-reset enabled raises the reset.
    assert_clear_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ((cfg_addr & WORD_MASK) == 8'h04) && cfg_be[0] && !cfg_wdata[BM_BIT]
         && bus_master_en && !reg_q[IDX_ICTL][AUTO_OFF_BIT] && !sw_rst) |=> sw_rst);
    // R4: with auto-reset disabled a command write starts no reset.
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ((cfg_addr & WORD_MASK) == 8'h04) && reg_q[IDX_ICTL][AUTO_OFF_BIT]
         && !sw_rst) |=> !sw_rst);
    // R7: the software-reset bit tracks the pulse exactly.
    assert_swrst_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q[IDX_MISC][SWRST_BIT] == sw_rst);
    // R8: bus mastering is off whenever the reset pulse is high.
    assert_bm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> !bus_master_en);
    // R9: the reset leaves the interface control register untouched.
    assert_ictl_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst && !wr_sel[IDX_ICTL]) |=> $stable(reg_q[IDX_ICTL]));
endmodule

// File: tb/cfg_autoreset_ctrl_test.sv
module cfg_autoreset_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic        bus_master_en;
    logic        sw_rst;

    cfg_autoreset_ctrl #(.RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .bus_master_en(bus_master_en), .sw_rst(sw_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        int          kind;   // 0 sw_rst, 1 bus_master_en, 2 cfg_rdata
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    logic  mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard insert, kept ordered by cycle.
    task automatic push(input int c, input int k, input logic [31:0] e, input string r);
        item_t it;
        int pos;
        it.cyc = c; it.kind = k; it.exp = e; it.req = r;
        pos = sb.size();
        while (pos > 0 && sb[pos-1].cyc > c) pos--;
        sb.insert(pos, it);
    endtask

    // Monitor: compare due items at the falling edge.
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        if (mon_on) begin
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                it = sb.pop_front();
                act = (it.kind == 0) ? {31'b0, sw_rst} :
                      (it.kind == 1) ? {31'b0, bus_master_en} : cfg_rdata;
                checks++;
                if (it.cyc != cyc || act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                             it.req, it.kind, it.cyc, act, it.exp);
                end
            end
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b,
                         output int p);
        p = cyc;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input string r);
        cfg_addr = a;
        push(cyc, 2, e, r);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Expected pulse starting the cycle after write cycle p.
    task automatic exp_pulse(input int p, input string r);
        for (int c = p + 1; c <= p + RSTC; c++) begin
            push(c, 0, 32'd1, r);
            push(c, 1, 32'd0, "R8");
        end
        push(p + RSTC + 1, 0, 32'd0, r);
        push(p + RSTC + 2, 0, 32'd0, r);
    endtask

    task automatic exp_quiet(input int p, input int n, input string r);
        for (int c = p + 1; c <= p + n; c++) push(c, 0, 32'd0, r);
    endtask

    int p;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: defaults after hardware reset
        push(cyc, 0, 32'd0, "R1");
        push(cyc, 1, 32'd0, "R1");
        do_rd(8'h04, 32'h0, "R1");
        do_rd(8'h54, 32'h0, "R1");
        do_rd(8'h40, 32'h0, "R1");
        do_rd(8'h20, 32'h0, "R2");

        // R2 / R11: full write of command, bus-master follows bit 2
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        push(p + 1, 1, 32'd1, "R11");
        do_rd(8'h07, 32'h0000_0147, "R2");

        // R6: clear attempt without lane 0 enable
        do_wr(8'h04, 32'h0000_0100, 4'b1110, p);
        exp_quiet(p, RSTC + 2, "R6");
        push(p + 1, 1, 32'd1, "R6");
        do_rd(8'h04, 32'h0000_0147, "R6");
        idle(RSTC + 1);

        // R5: rewriting a set bus-master bit
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        exp_quiet(p, RSTC + 2, "R5");
        idle(RSTC + 2);

        // R10: interface control with reserved pattern, bit 16 = 0
        do_wr(8'h54, 32'hA5A4_5A5A, 4'hF, p);
        do_rd(8'h54, 32'hA5A4_5A5A, "R10");

        // R3: one-to-zero clear triggers the pulse
        do_wr(8'h04, 32'h0000_0143, 4'hF, p);
        exp_pulse(p, "R3");
        idle(RSTC + 3);
        do_rd(8'h04, 32'h0000_0143, "R9");
        do_rd(8'h54, 32'hA5A4_5A5A, "R9");
        do_rd(8'h40, 32'h0000_0000, "R7");

        // R5: clearing an already-zero bit
        do_wr(8'h04, 32'h0000_0143, 4'hF, p);
        exp_quiet(p, RSTC + 2, "R5");
        idle(RSTC + 2);

        // R7 / R8: explicit software reset, writes during the pulse
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        push(p + 1, 1, 32'd1, "R11");
        do_wr(8'h40, 32'h8000_0001, 4'hF, p);
        exp_pulse(p, "R7");
        do_rd(8'h40, 32'h8000_0001, "R7");
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        idle(RSTC + 2);
        push(cyc, 1, 32'd0, "R8");
        do_rd(8'h04, 32'h0000_0143, "R8");
        do_rd(8'h40, 32'h0000_0001, "R7");

        // R4: auto-reset disabled
        do_wr(8'h54, 32'hA5A5_5A5A, 4'hF, p);
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        do_wr(8'h04, 32'h0000_0143, 4'hF, p);
        exp_quiet(p, RSTC + 2, "R4");
        push(p + 1, 1, 32'd0, "R4");
        idle(RSTC + 2);

        // R6: lane 2 disabled keeps bit 16 set
        do_wr(8'h54, 32'h0000_0000, 4'b1011, p);
        do_rd(8'h54, 32'h00A5_0000, "R6");

        // R3: re-enable, clear through lane 0 only
        do_wr(8'h54, 32'h0000_0000, 4'hF, p);
        do_wr(8'h04, 32'h0000_0147, 4'hF, p);
        do_wr(8'h04, 32'h0000_0000, 4'b0001, p);
        exp_pulse(p, "R3");
        idle(RSTC + 3);
        do_rd(8'h04, 32'h0000_0100, "R9");

        idle(2);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule